// File: doc/BRIEF.md
# Distributed Arithmetic Inner Product

This block forms the dot product of a vector of signed sample words with a constant coefficient vector, and it does so without multipliers. The coefficients are fixed when the block is built. Elaboration folds them into small partial-sum tables, one table per group of taps.

A computation starts on a start pulse. It then walks through the captured samples one bit position per clock, beginning at the least significant bit. At each bit position the block collects that bit from every sample. Each group's slice of those bits selects a precomputed coefficient sum from the group's table, and the table outputs are added together. The total is weighted by the bit position and folded into a carry-save accumulator.

The sign bit position is subtracted rather than added. After the last bit, one carry-propagate add produces the full-precision result, and a one-cycle done pulse marks it. The number of cycles is always the same, whatever the data.

A separate load strobe writes a staging register that holds the sample vector. A start pulse copies the staging register into the engine, so the next vector can be loaded while the current one is being computed.

Top module: `da_inner_product`

## Requirements
- R1: When done_o is high, result_o holds the exact signed value of the sum over all taps of sample times coefficient, sign-extended to ACC_W = DATA_W + COEF_W + clog2(NUM_TAPS) bits.
- R2: A start pulse sampled while the block is idle makes done_o go high after exactly DATA_W+1 further rising edges, whatever the sample values. done_o stays low on all the edges in between.
- R3: done_o is high for exactly one clock cycle per computation.
- R4: A start pulse sampled while a computation or its final add is in progress is ignored. The running computation keeps its timing and its result.
- R5: load_i writes samples_i into the staging register at any time. An accepted start copies the staging contents that existed before that edge. A load made during a computation does not change that computation's result, and the loaded vector stays in place for the next start.
- R6: Samples are two's complement. The sign bit carries weight -2^(DATA_W-1), so vectors made entirely of the most negative value give the exact result.
- R7: result_o changes only at the edge that raises done_o, and it holds its value until the next completion.
- R8: While rst_ni is low, result_o reads 0 and done_o reads 0.
- R9: Sample t sits at samples_i[t*DATA_W +: DATA_W] and coefficient t sits at COEFS[t*COEF_W +: COEF_W]. Taps are grouped GROUP_TAPS at a time, and tap t drives address bit t mod GROUP_TAPS of table t / GROUP_TAPS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Write samples_i into the staging register |
| samples_i | input | NUM_TAPS*DATA_W | Packed signed sample vector, tap 0 in the low bits |
| start_i | input | 1 | Begin a computation on the staged vector |
| result_o | output | ACC_W | Signed inner product, held between completions |
| done_o | output | 1 | One-cycle pulse when result_o updates |

## Verification
The hardest case to reach is a start pulse and a fresh load that arrive in the middle of a running computation. If the engine restarted, or recaptured the staging register, the error would show only as a shifted done pulse or a mixed result. To reach it, the bench stages vector A, starts it, and three bit cycles later drives a load of vector B and a second start in the same cycle. It then checks that done appears on A's original schedule with A's value. A further start with no reload must then return B's value. The bench also runs an all-most-negative vector to exercise the subtracted sign cycle at its largest magnitude.

// File: rtl/da_pkg.sv
package da_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } da_state_e;
endpackage

// File: rtl/da_sample_shifter.sv
module da_sample_shifter #(
  parameter int NUM_TAPS = 8,
  parameter int DATA_W   = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [NUM_TAPS*DATA_W-1:0]   samples_i,
  input  logic                         capture_i,
  input  logic                         shift_i,
  output logic [NUM_TAPS-1:0]          bits_o
);
  logic [DATA_W-1:0] stage_q [NUM_TAPS];
  logic [DATA_W-1:0] shreg_q [NUM_TAPS];

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[t] <= '0;
      else if (load_i) stage_q[t] <= samples_i[t*DATA_W +: DATA_W];
    end

    // capture reads the staging value from before this edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        shreg_q[t] <= '0;
      else if (capture_i) shreg_q[t] <= stage_q[t];
      else if (shift_i)   shreg_q[t] <= {1'b0, shreg_q[t][DATA_W-1:1]};
    end

    assign bits_o[t] = shreg_q[t][0];
  end
endmodule

// File: rtl/da_part_rom.sv
module da_part_rom #(
  parameter int                          GROUP_TAPS = 4,
  parameter int                          COEF_W     = 8,
  parameter int                          ENT_W      = 10,
  parameter logic [GROUP_TAPS*COEF_W-1:0] GRP_COEFS = '0
) (
  input  logic [GROUP_TAPS-1:0]     addr_i,
  output logic signed [ENT_W-1:0]   entry_o
);
  localparam int DEPTH = 1 << GROUP_TAPS;

  function automatic logic signed [ENT_W-1:0] entry_val(input int a);
    logic signed [ENT_W-1:0] acc;
    acc = '0;
    for (int t = 0; t < GROUP_TAPS; t++)
      if (a[t]) acc = acc + ENT_W'($signed(GRP_COEFS[t*COEF_W +: COEF_W]));
    return acc;
  endfunction

  logic signed [ENT_W-1:0] lut_w [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_ent
    assign lut_w[a] = entry_val(a);
  end

  assign entry_o = lut_w[addr_i];
endmodule

// File: rtl/da_csa_acc.sv
module da_csa_acc #(
  parameter int ACC_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             neg_i,
  input  logic [ACC_W-1:0] addend_i,
  output logic [ACC_W-1:0] sum_o,
  output logic [ACC_W-1:0] carry_o
);
  logic [ACC_W-1:0] x_w, s_d, maj_w, c_d;

  // subtract = add inverted operand, +1 goes into the free carry LSB
  always_comb begin
    x_w   = neg_i ? ~addend_i : addend_i;
    s_d   = sum_o ^ carry_o ^ x_w;
    maj_w = (sum_o & carry_o) | (sum_o & x_w) | (carry_o & x_w);
    c_d   = {maj_w[ACC_W-2:0], neg_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o   <= '0;
      carry_o <= '0;
    end else if (clr_i) begin
      sum_o   <= '0;
      carry_o <= '0;
    end else if (en_i) begin
      sum_o   <= s_d;
      carry_o <= c_d;
    end
  end
endmodule

// File: rtl/da_inner_product.sv
module da_inner_product
  import da_pkg::*;
#(
  parameter int                        NUM_TAPS   = 8,
  parameter int                        GROUP_TAPS = 4,
  parameter int                        DATA_W     = 8,
  parameter int                        COEF_W     = 8,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS     = 64'h11807FFF40DB0564,
  localparam int                       ACC_W      = DATA_W + COEF_W + $clog2(NUM_TAPS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [NUM_TAPS*DATA_W-1:0] samples_i,
  input  logic                       start_i,
  output logic [ACC_W-1:0]           result_o,
  output logic                       done_o
);
  localparam int NUM_GROUPS = NUM_TAPS / GROUP_TAPS;
  localparam int ENT_W      = COEF_W + $clog2(GROUP_TAPS);
  localparam int CNT_W      = $clog2(DATA_W);
  localparam int GRP_BITS   = GROUP_TAPS * COEF_W;

  da_state_e           state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                start_ok_w, run_w, last_w;
  logic [NUM_TAPS-1:0] tap_bits_w;
  logic signed [ENT_W-1:0] ent_w [NUM_GROUPS];
  logic [ACC_W-1:0]    psum_w, addend_w, sum_w, carry_w;

  assign start_ok_w = start_i && (state_q == ST_IDLE);
  assign run_w      = (state_q == ST_RUN);
  assign last_w     = (cnt_q == CNT_W'(DATA_W - 1));

  da_sample_shifter #(.NUM_TAPS(NUM_TAPS), .DATA_W(DATA_W)) shifter_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .samples_i (samples_i),
    .capture_i (start_ok_w),
    .shift_i   (run_w),
    .bits_o    (tap_bits_w)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    da_part_rom #(
      .GROUP_TAPS (GROUP_TAPS),
      .COEF_W     (COEF_W),
      .ENT_W      (ENT_W),
      .GRP_COEFS  (COEFS[g*GRP_BITS +: GRP_BITS])
    ) rom_i (
      .addr_i  (tap_bits_w[g*GROUP_TAPS +: GROUP_TAPS]),
      .entry_o (ent_w[g])
    );
  end

  always_comb begin
    psum_w = '0;
    for (int g = 0; g < NUM_GROUPS; g++)
      psum_w = psum_w + ACC_W'(ent_w[g]);
    addend_w = psum_w << cnt_q;
  end

  // sign bit cycle subtracts
  da_csa_acc #(.ACC_W(ACC_W)) acc_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_ok_w),
    .en_i     (run_w),
    .neg_i    (last_w),
    .addend_i (addend_w),
    .sum_o    (sum_w),
    .carry_o  (carry_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (last_w) state_q <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= (state_q == ST_FIN);
      if (state_q == ST_FIN) result_o <= sum_w + carry_w;
    end
  end
endmodule

// File: rtl/da_inner_product_chk.sv
module da_inner_product_chk
  import da_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 19,
  parameter int CNT_W  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             done_o,
  input logic [ACC_W-1:0] result_o,
  input da_state_e        state_q,
  input logic [CNT_W-1:0] cnt_q
);
  localparam int LAT   = DATA_W + 2;
  localparam int LAT_W = $clog2(LAT + 1);

  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 lat_q <= '0;
    else if (start_i && state_q == ST_IDLE)      lat_q <= LAT_W'(1);
    else if (lat_q != '0 && lat_q < LAT_W'(LAT)) lat_q <= lat_q + LAT_W'(1);
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2
  done_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> lat_q == LAT_W'(LAT));

  // R7
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> done_o);

  // R4
  run_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && cnt_q != CNT_W'(DATA_W - 1))
    |=> (state_q == ST_RUN && cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

bind da_inner_product da_inner_product_chk #(
  .DATA_W (DATA_W),
  .ACC_W  (ACC_W),
  .CNT_W  ($clog2(DATA_W))
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .done_o   (done_o),
  .result_o (result_o),
  .state_q  (state_q),
  .cnt_q    (cnt_q)
);

// File: tb/da_inner_product_tb_top.sv
module da_inner_product_tb_top;
  localparam int NUM_TAPS   = 8;
  localparam int GROUP_TAPS = 4;
  localparam int DATA_W     = 8;
  localparam int COEF_W     = 8;
  localparam int ACC_W      = DATA_W + COEF_W + $clog2(NUM_TAPS);
  localparam logic [NUM_TAPS*COEF_W-1:0] COEFS = 64'h11807FFF40DB0564;
  localparam int VBITS = NUM_TAPS * DATA_W;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             load_i = 1'b0;
  logic             start_i = 1'b0;
  logic [VBITS-1:0] samples_i = '0;
  logic [ACC_W-1:0] result_o;
  logic             done_o;

  int checks = 0;
  int errors = 0;
  int seed   = 32'h1234_5678;

  always #5 clk_i = ~clk_i;  // 10 ns period, 100 MHz

  da_inner_product #(
    .NUM_TAPS(NUM_TAPS), .GROUP_TAPS(GROUP_TAPS), .DATA_W(DATA_W),
    .COEF_W(COEF_W), .COEFS(COEFS)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .samples_i(samples_i),
    .start_i(start_i), .result_o(result_o), .done_o(done_o)
  );

  function automatic longint ref_dot(input logic [VBITS-1:0] v);
    longint acc = 0;
    for (int t = 0; t < NUM_TAPS; t++)
      acc += longint'($signed(v[t*DATA_W +: DATA_W])) *
             longint'($signed(COEFS[t*COEF_W +: COEF_W]));
    return acc;
  endfunction

  function automatic logic [VBITS-1:0] fill(input logic [DATA_W-1:0] val);
    logic [VBITS-1:0] v;
    for (int t = 0; t < NUM_TAPS; t++) v[t*DATA_W +: DATA_W] = val;
    return v;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic load_vec(input logic [VBITS-1:0] v);
    @(negedge clk_i);
    load_i = 1'b1; samples_i = v;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  // start, follow the latency, check result; optional mid-run load+start
  task automatic run_calc(input string req, input longint exp,
                          input bit inject, input logic [VBITS-1:0] inj_v);
    logic [ACC_W-1:0] held;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    for (int n = 1; n <= DATA_W; n++) begin
      @(negedge clk_i);
      check({"R2 done early ", req}, longint'(done_o), 0);
      if (inject && n == 3) begin
        load_i = 1'b1; samples_i = inj_v; start_i = 1'b1;
      end else begin
        load_i = 1'b0; start_i = 1'b0;
      end
    end
    @(negedge clk_i);
    check({"R2 done on time ", req}, longint'(done_o), 1);
    check({"R1 ", req}, longint'($signed(result_o)), exp);
    held = result_o;
    @(negedge clk_i);
    check({"R3 done width ", req}, longint'(done_o), 0);
    check({"R7 hold ", req}, longint'(result_o), longint'(held));
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R8 result in reset", longint'(result_o), 0);
    check("R8 done in reset", longint'(done_o), 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_patterns();
    logic [VBITS-1:0] v;
    v = '0;
    load_vec(v); run_calc("zero", ref_dot(v), 1'b0, '0);
    v = '0; v[6*DATA_W +: DATA_W] = 8'd1;  // coef tap 6 = -128
    load_vec(v); run_calc("R9 tap6 one-hot", -128, 1'b0, '0);
    v = '0; v[0 +: DATA_W] = 8'd1;         // coef tap 0 = 100
    load_vec(v); run_calc("R9 tap0 one-hot", 100, 1'b0, '0);
    v = fill(8'h7F);
    load_vec(v); run_calc("all max", ref_dot(v), 1'b0, '0);
    v = 64'hF0_0C_81_7E_33_C5_02_FE;
    load_vec(v); run_calc("mixed", ref_dot(v), 1'b0, '0);
    for (int i = 0; i < 6; i++) begin
      for (int t = 0; t < NUM_TAPS; t++) begin
        seed = seed * 1103515245 + 12345;
        v[t*DATA_W +: DATA_W] = seed[23:16];
      end
      load_vec(v); run_calc("pseudo random", ref_dot(v), 1'b0, '0);
    end
  endtask

  task automatic t_minimum();
    logic [VBITS-1:0] v;
    v = fill(8'h80);
    load_vec(v); run_calc("R6 all most-negative", ref_dot(v), 1'b0, '0);
    v = '0; v[6*DATA_W +: DATA_W] = 8'h80;  // -128 * -128
    load_vec(v); run_calc("R6 min times min", 16384, 1'b0, '0);
  endtask

  task automatic t_busy_start();
    logic [VBITS-1:0] va, vb;
    va = 64'h01_80_7F_FF_10_EE_05_9C;
    vb = 64'h7F_01_80_22_FD_40_11_C3;
    load_vec(va);
    run_calc("R4 R5 start while busy keeps A", ref_dot(va), 1'b1, vb);
    run_calc("R5 staged B used by next start", ref_dot(vb), 1'b0, '0);
  endtask

  initial begin
    t_reset();
    t_patterns();
    t_minimum();
    t_busy_start();
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    summary();
    $finish;
  end
endmodule